// File: doc/BRIEF.md
# Region-Aware Bus Width Adapter

This block sits between a 16-bit processor data bus and the address space of a chip's peripherals and memory. Each access carries an address, a read or write strobe, a byte/word flag and write data. The block sorts the access into one of four regions: byte-organised system control registers, narrow (8-bit) peripherals, wide (16-bit) peripherals, or memory. It raises one select for that region and reshapes the access to the width the target expects.

On writes it produces byte-lane enables and lane-placed write data. A word written to a narrow peripheral keeps only its low byte. Accesses the bus rules forbid raise an error flag and never reach a target: a word at an odd address, a word into the control-register space, or a byte at an odd address in the wide-peripheral space. On reads the block picks the addressed lane from the target's 16-bit data and returns it zero-extended on the low lane. A byte read from a wide peripheral gets a zero high byte. A word read from a narrow peripheral gets a fixed filler high byte and a warning flag. The formatted read data is registered once and returned in the cycle after the strobe.

Top module: `pbus_width_adapter`

## Requirements
- R1: Address 0x0000–0x000F selects the control-register region, 0x0010–0x00FF the narrow-peripheral region, 0x0100–0x01FF the wide-peripheral region and 0x0200–0xFFFF memory. At most one select (`sel_sfr`, `sel_p8`, `sel_p16`, `sel_mem`) is high. A select is high only while `cpu_rd` or `cpu_wr` is high and the access is legal.
- R2: A word access (`cpu_byte`=0) to the control-register region raises `acc_err`. Byte accesses to any address in that region are legal.
- R3: A word write to the narrow-peripheral region drives `tgt_be`=2'b01, carries the low data byte on `tgt_wdata[7:0]`, and leaves the byte at the odd address unchanged.
- R4: A word read from the narrow-peripheral region returns the target's low lane in `cpu_rdata[7:0]` and the filler value 0xFF in `cpu_rdata[15:8]`. It sets `undef_warn` in the same cycle as the data. Any other read clears `undef_warn`.
- R5: A byte access to an odd address in the wide-peripheral region raises `acc_err`. A byte read at an even address there returns the target's low lane with `cpu_rdata[15:8]`=0.
- R6: A word access to an odd address in any region raises `acc_err`. Whenever `acc_err` is high, `tgt_we` and all selects are low, so no target state changes.
- R7: Legal byte writes set `tgt_be`=2'b01 at an even address and 2'b10 at an odd address. The data byte appears on both lanes of `tgt_wdata`. Legal word writes outside the narrow region set `tgt_be`=2'b11.
- R8: A byte read takes the target's high lane (`tgt_rdata[15:8]`) at an odd address and its low lane at an even address. It returns that byte in `cpu_rdata[7:0]` with the upper byte zero.
- R9: `cpu_rdata` and `cpu_rvalid` update at the clock edge that ends a cycle with `cpu_rd` high. A read that raises `acc_err` returns 0x0000 with `cpu_rvalid`=1. In cycles without `cpu_rd`, `cpu_rdata` holds and `cpu_rvalid` is 0.
- R10: After reset, `cpu_rdata`=0, `cpu_rvalid`=0 and `undef_warn`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_byte | input | 1 | 1 = byte access, 0 = word access |
| cpu_wdata | input | 16 | Write data; a byte is in bits 7:0 |
| sel_sfr | output | 1 | Control-register region select |
| sel_p8 | output | 1 | Narrow-peripheral region select |
| sel_p16 | output | 1 | Wide-peripheral region select |
| sel_mem | output | 1 | Memory region select |
| tgt_addr | output | 16 | Address forwarded to the target |
| tgt_we | output | 1 | Write enable to the target |
| tgt_be | output | 2 | Byte-lane enables (bit 0 = even byte) |
| tgt_wdata | output | 16 | Lane-placed write data |
| tgt_rdata | input | 16 | Target read data, valid in the strobe cycle |
| cpu_rdata | output | 16 | Registered, formatted read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| acc_err | output | 1 | Illegal access: write suppressed, read returns zero |
| undef_warn | output | 1 | Word read from the narrow region; high byte is filler |

## Verification
The hardest case to reach from the ports is a rejected write that leaves a target untouched. The error path shows no data of its own, so suppression is only visible through the later contents of the target. The bench keeps a byte-array model behind the target port, preloaded with an address-derived pattern. After each illegal odd-address write it reads the neighbouring legal word back and compares it with the pattern. The narrow-region word write is checked the same way: a byte read of the odd neighbour afterwards shows whether the high byte leaked through.

// File: rtl/pbwa_pkg.sv
package pbwa_pkg;

   typedef enum logic [1:0] {
      RGN_CTRL = 2'd0,
      RGN_NARROW = 2'd1,
      RGN_WIDE = 2'd2,
      RGN_MEM = 2'd3
   } region_e;

   localparam int LANE_W = 8;
   localparam int LANES = 2;
   localparam int BUS_W = LANE_W * LANES;

endpackage

// File: rtl/pbwa_region_dec.sv
module pbwa_region_dec
   import pbwa_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] CTRL_LAST = 16'h000F,
   parameter logic [ADDR_W-1:0] NARROW_LAST = 16'h00FF,
   parameter logic [ADDR_W-1:0] WIDE_LAST = 16'h01FF
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);

   always_comb begin
      if (addr <= CTRL_LAST)        region = RGN_CTRL;
      else if (addr <= NARROW_LAST) region = RGN_NARROW;
      else if (addr <= WIDE_LAST)   region = RGN_WIDE;
      else                          region = RGN_MEM;
   end

endmodule

// File: rtl/pbwa_access_check.sv
module pbwa_access_check
   import pbwa_pkg::*;
(
   input  region_e region,
   input  logic    odd_addr,
   input  logic    byte_acc,
   input  logic    rd,
   input  logic    wr,
   output logic    acc_err,
   output logic    acc_ok
);

   logic req;
   logic bad_word_align;
   logic bad_ctrl_word;
   logic bad_wide_byte;

   assign req = rd | wr;

   always_comb begin
      bad_word_align = !byte_acc && odd_addr;
      bad_ctrl_word  = !byte_acc && (region == RGN_CTRL);
      bad_wide_byte  = byte_acc && odd_addr && (region == RGN_WIDE);
   end

   assign acc_err = req & (bad_word_align | bad_ctrl_word | bad_wide_byte);
   assign acc_ok  = req & ~acc_err;

endmodule

// File: rtl/pbwa_write_lanes.sv
module pbwa_write_lanes
   import pbwa_pkg::*;
#(
   parameter bit BYTE_REPLICATE = 1'b1
) (
   input  region_e           region,
   input  logic              odd_addr,
   input  logic              byte_acc,
   input  logic [BUS_W-1:0]  wdata_in,
   output logic [LANES-1:0]  be,
   output logic [BUS_W-1:0]  wdata_out
);

   logic [LANE_W-1:0] low_byte;
   logic [BUS_W-1:0]  byte_placed;

   assign low_byte = wdata_in[LANE_W-1:0];

   generate
      if (BYTE_REPLICATE) begin : g_replicate
         assign byte_placed = {LANES{low_byte}};
      end else begin : g_steer
         assign byte_placed = odd_addr ? {low_byte, {LANE_W{1'b0}}}
                                       : {{LANE_W{1'b0}}, low_byte};
      end
   endgenerate

   always_comb begin
      if (byte_acc) begin
         be        = odd_addr ? 2'b10 : 2'b01;
         wdata_out = byte_placed;
      end else if (region == RGN_NARROW) begin
         be        = 2'b01;
         wdata_out = {{LANE_W{1'b0}}, low_byte};
      end else begin
         be        = 2'b11;
         wdata_out = wdata_in;
      end
   end

endmodule

// File: rtl/pbwa_read_fmt.sv
module pbwa_read_fmt
   import pbwa_pkg::*;
#(
   parameter logic [LANE_W-1:0] UNDEF_FILL = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              acc_err,
   input  region_e           region,
   input  logic              odd_addr,
   input  logic              byte_acc,
   input  logic [BUS_W-1:0]  tgt_rdata,
   output logic [BUS_W-1:0]  rdata,
   output logic              rvalid,
   output logic              warn
);

   logic [BUS_W-1:0]  fmt_data;
   logic [LANE_W-1:0] picked;
   logic              narrow_word;

   assign picked      = odd_addr ? tgt_rdata[BUS_W-1:LANE_W] : tgt_rdata[LANE_W-1:0];
   assign narrow_word = !byte_acc && (region == RGN_NARROW);

   always_comb begin
      if (byte_acc)
         fmt_data = {{LANE_W{1'b0}}, picked};
      else if (narrow_word)
         fmt_data = {UNDEF_FILL, tgt_rdata[LANE_W-1:0]};
      else
         fmt_data = tgt_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
         warn   <= 1'b0;
      end else begin
         rvalid <= rd;
         if (rd) begin
            rdata <= acc_err ? '0 : fmt_data;
            warn  <= !acc_err && narrow_word;
         end
      end
   end

endmodule

// File: rtl/pbus_width_adapter.sv
module pbus_width_adapter
   import pbwa_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] CTRL_LAST = 16'h000F,
   parameter logic [ADDR_W-1:0] NARROW_LAST = 16'h00FF,
   parameter logic [ADDR_W-1:0] WIDE_LAST = 16'h01FF,
   parameter logic [7:0] UNDEF_FILL = 8'hFF,
   parameter bit BYTE_REPLICATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic              cpu_byte,
   input  logic [15:0]       cpu_wdata,
   output logic              sel_sfr,
   output logic              sel_p8,
   output logic              sel_p16,
   output logic              sel_mem,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic              tgt_we,
   output logic [1:0]        tgt_be,
   output logic [15:0]       tgt_wdata,
   input  logic [15:0]       tgt_rdata,
   output logic [15:0]       cpu_rdata,
   output logic              cpu_rvalid,
   output logic              acc_err,
   output logic              undef_warn
);

   initial begin
      assert (ADDR_W >= 10) else $error("ADDR_W too small for region map");
      assert (CTRL_LAST < NARROW_LAST) else $error("region bounds out of order");
      assert (NARROW_LAST < WIDE_LAST) else $error("region bounds out of order");
      assert (CTRL_LAST[0] && NARROW_LAST[0] && WIDE_LAST[0])
         else $error("region ends must be odd addresses");
   end

   region_e region;
   logic    acc_ok;
   logic    odd_addr;

   assign odd_addr = cpu_addr[0];
   assign tgt_addr = cpu_addr;

   pbwa_region_dec #(
      .ADDR_W(ADDR_W),
      .CTRL_LAST(CTRL_LAST),
      .NARROW_LAST(NARROW_LAST),
      .WIDE_LAST(WIDE_LAST)
   ) dec_i (
      .addr(cpu_addr),
      .region(region)
   );

   pbwa_access_check chk_i (
      .region(region),
      .odd_addr(odd_addr),
      .byte_acc(cpu_byte),
      .rd(cpu_rd),
      .wr(cpu_wr),
      .acc_err(acc_err),
      .acc_ok(acc_ok)
   );

   pbwa_write_lanes #(
      .BYTE_REPLICATE(BYTE_REPLICATE)
   ) wl_i (
      .region(region),
      .odd_addr(odd_addr),
      .byte_acc(cpu_byte),
      .wdata_in(cpu_wdata),
      .be(tgt_be),
      .wdata_out(tgt_wdata)
   );

   pbwa_read_fmt #(
      .UNDEF_FILL(UNDEF_FILL)
   ) rf_i (
      .clk(clk),
      .rst_n(rst_n),
      .rd(cpu_rd),
      .acc_err(acc_err),
      .region(region),
      .odd_addr(odd_addr),
      .byte_acc(cpu_byte),
      .tgt_rdata(tgt_rdata),
      .rdata(cpu_rdata),
      .rvalid(cpu_rvalid),
      .warn(undef_warn)
   );

   assign sel_sfr = acc_ok && (region == RGN_CTRL);
   assign sel_p8  = acc_ok && (region == RGN_NARROW);
   assign sel_p16 = acc_ok && (region == RGN_WIDE);
   assign sel_mem = acc_ok && (region == RGN_MEM);
   assign tgt_we  = cpu_wr && acc_ok;

endmodule

// File: rtl/pbwa_checker.sv
module pbwa_checker #(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] CTRL_LAST = 16'h000F,
   parameter logic [7:0] UNDEF_FILL = 8'hFF
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic              cpu_byte,
   input logic              sel_sfr,
   input logic              sel_p8,
   input logic              sel_p16,
   input logic              sel_mem,
   input logic              tgt_we,
   input logic [1:0]        tgt_be,
   input logic [15:0]       cpu_rdata,
   input logic              cpu_rvalid,
   input logic              acc_err,
   input logic              undef_warn
);

   logic [3:0] sels;
   assign sels = {sel_sfr, sel_p8, sel_p16, sel_mem};

   a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sels));

   a_r1_sel_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_rd && !cpu_wr) |-> (sels == 4'b0000));

   a_r2_ctrl_word_err: assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_rd || cpu_wr) && !cpu_byte && (cpu_addr <= CTRL_LAST)) |-> acc_err);

   a_r3_narrow_word_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_p8 && tgt_we && !cpu_byte) |-> (tgt_be == 2'b01));

   a_r4_warn_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && sel_p8 && !cpu_byte) |=> (undef_warn && cpu_rdata[15:8] == UNDEF_FILL));

   a_r5_wide_byte_zero_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && sel_p16 && cpu_byte) |=> (cpu_rdata[15:8] == 8'h00));

   a_r6_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> (!tgt_we && sels == 4'b0000));

   a_r6_odd_word_err: assert property (@(posedge clk) disable iff (!rst_n)
      ((cpu_rd || cpu_wr) && !cpu_byte && cpu_addr[0]) |-> acc_err);

   a_r7_byte_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_we && cpu_byte) |-> (tgt_be == (cpu_addr[0] ? 2'b10 : 2'b01)));

   a_r8_byte_read_zext: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && cpu_byte) |=> (cpu_rdata[15:8] == 8'h00));

   a_r9_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd |=> cpu_rvalid);

   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> (!cpu_rvalid && $stable(cpu_rdata)));

endmodule

bind pbus_width_adapter pbwa_checker #(
   .ADDR_W(ADDR_W),
   .CTRL_LAST(CTRL_LAST),
   .UNDEF_FILL(UNDEF_FILL)
) pbwa_checker_i (
   .clk(clk),
   .rst_n(rst_n),
   .cpu_addr(cpu_addr),
   .cpu_rd(cpu_rd),
   .cpu_wr(cpu_wr),
   .cpu_byte(cpu_byte),
   .sel_sfr(sel_sfr),
   .sel_p8(sel_p8),
   .sel_p16(sel_p16),
   .sel_mem(sel_mem),
   .tgt_we(tgt_we),
   .tgt_be(tgt_be),
   .cpu_rdata(cpu_rdata),
   .cpu_rvalid(cpu_rvalid),
   .acc_err(acc_err),
   .undef_warn(undef_warn)
);

// File: tb/pbus_width_adapter_tb.sv
`timescale 1ns/1ps
module pbus_width_adapter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic        cpu_byte = 1'b0;
   logic [15:0] cpu_wdata = '0;
   logic        sel_sfr, sel_p8, sel_p16, sel_mem;
   logic [15:0] tgt_addr;
   logic        tgt_we;
   logic [1:0]  tgt_be;
   logic [15:0] tgt_wdata;
   logic [15:0] tgt_rdata;
   logic [15:0] cpu_rdata;
   logic        cpu_rvalid;
   logic        acc_err;
   logic        undef_warn;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pbus_width_adapter dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_byte(cpu_byte), .cpu_wdata(cpu_wdata),
      .sel_sfr(sel_sfr), .sel_p8(sel_p8), .sel_p16(sel_p16), .sel_mem(sel_mem),
      .tgt_addr(tgt_addr), .tgt_we(tgt_we), .tgt_be(tgt_be),
      .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
      .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
      .acc_err(acc_err), .undef_warn(undef_warn)
   );

   // Target model: flat byte array behind a 16-bit lane interface
   logic [7:0] bmem [0:1023];

   function automatic logic [7:0] pat(input logic [15:0] a);
      return a[7:0] ^ 8'h5A;
   endfunction

   initial begin
      for (int i = 0; i < 1024; i++) bmem[i] = pat(16'(i));
   end

   always_comb begin
      if (sel_sfr | sel_p8 | sel_p16 | sel_mem)
         tgt_rdata = {bmem[{tgt_addr[9:1], 1'b1}], bmem[{tgt_addr[9:1], 1'b0}]};
      else
         tgt_rdata = 16'hDEAD;
   end

   always @(posedge clk) begin
      if (tgt_we) begin
         if (tgt_be[0]) bmem[{tgt_addr[9:1], 1'b0}] <= tgt_wdata[7:0];
         if (tgt_be[1]) bmem[{tgt_addr[9:1], 1'b1}] <= tgt_wdata[15:8];
      end
   end

   // Samples captured by acc()
   logic [3:0]  s_sel;
   logic        s_err, s_we;
   logic [1:0]  s_be;
   logic [15:0] s_wd, r_data;
   logic        r_valid, r_warn;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic acc(input logic [15:0] a, input bit rd, input bit wr, input bit by, input logic [15:0] wd);
      @(negedge clk);
      cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_byte = by; cpu_wdata = wd;
      #1;
      s_sel = {sel_sfr, sel_p8, sel_p16, sel_mem};
      s_err = acc_err; s_we = tgt_we; s_be = tgt_be; s_wd = tgt_wdata;
      @(negedge clk);
      r_data = cpu_rdata; r_valid = cpu_rvalid; r_warn = undef_warn;
      cpu_rd = 1'b0; cpu_wr = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk(cpu_rdata == 16'h0 && !cpu_rvalid && !undef_warn, "R10 reset outputs",
          {cpu_rdata, 7'b0, cpu_rvalid, 7'b0, undef_warn}, 0);
      chk({sel_sfr, sel_p8, sel_p16, sel_mem} == 4'b0, "R1 no select without strobe",
          {sel_sfr, sel_p8, sel_p16, sel_mem}, 0);
   endtask

   task automatic t_regions();
      acc(16'h0004, 1, 0, 1, 0); chk(s_sel == 4'b1000, "R1 0x0004 ctrl", s_sel, 4'b1000);
      acc(16'h000F, 1, 0, 1, 0); chk(s_sel == 4'b1000, "R1 0x000F ctrl", s_sel, 4'b1000);
      acc(16'h0010, 1, 0, 1, 0); chk(s_sel == 4'b0100, "R1 0x0010 narrow", s_sel, 4'b0100);
      acc(16'h00FF, 1, 0, 1, 0); chk(s_sel == 4'b0100, "R1 0x00FF narrow", s_sel, 4'b0100);
      acc(16'h0100, 1, 0, 0, 0); chk(s_sel == 4'b0010, "R1 0x0100 wide", s_sel, 4'b0010);
      acc(16'h01FE, 1, 0, 1, 0); chk(s_sel == 4'b0010, "R1 0x01FE wide", s_sel, 4'b0010);
      acc(16'h0200, 1, 0, 0, 0); chk(s_sel == 4'b0001, "R1 0x0200 mem", s_sel, 4'b0001);
      acc(16'hFFFE, 1, 0, 0, 0); chk(s_sel == 4'b0001, "R1 0xFFFE mem", s_sel, 4'b0001);
   endtask

   task automatic t_ctrl();
      acc(16'h0002, 1, 0, 0, 0);
      chk(s_err && s_sel == 4'b0, "R2 ctrl word read error", {s_err, s_sel}, 5'b10000);
      acc(16'h0005, 0, 1, 1, 16'h003C);
      chk(!s_err && s_we && s_be == 2'b10, "R7 ctrl odd byte be", {s_we, s_be}, 3'b110);
      chk(s_wd[15:8] == 8'h3C, "R7 byte on high lane", s_wd, 16'h3C3C);
      acc(16'h0005, 1, 0, 1, 0);
      chk(r_data == 16'h003C, "R8 odd byte read zext", r_data, 16'h003C);
      acc(16'h0004, 1, 0, 1, 0);
      chk(r_data == {8'h00, pat(16'h0004)}, "R8 even byte read", r_data, {8'h00, pat(16'h0004)});
   endtask

   task automatic t_narrow();
      acc(16'h0040, 0, 1, 0, 16'hBEEF);
      chk(s_we && s_be == 2'b01 && s_wd[7:0] == 8'hEF, "R3 narrow word write low lane",
          {s_we, s_be, s_wd}, {1'b1, 2'b01, 16'h00EF});
      acc(16'h0041, 1, 0, 1, 0);
      chk(r_data == {8'h00, pat(16'h0041)}, "R3 odd byte untouched", r_data, {8'h00, pat(16'h0041)});
      acc(16'h0040, 1, 0, 0, 0);
      chk(r_data == 16'hFFEF, "R4 narrow word read fill", r_data, 16'hFFEF);
      chk(r_warn, "R4 warn set", r_warn, 1);
      acc(16'h0040, 1, 0, 1, 0);
      chk(!r_warn && r_data == 16'h00EF, "R4 warn clears on byte read", {r_warn, r_data}, 16'h00EF);
      acc(16'h0041, 1, 0, 0, 0);
      chk(s_err && r_data == 16'h0 && r_valid, "R6 narrow odd word read error",
          {s_err, r_valid, r_data}, {2'b11, 16'h0});
   endtask

   task automatic t_wide();
      acc(16'h0121, 1, 0, 1, 0);
      chk(s_err && s_sel == 4'b0, "R5 wide odd byte error", {s_err, s_sel}, 5'b10000);
      chk(r_valid && r_data == 16'h0, "R9 error read returns zero", {r_valid, r_data}, {1'b1, 16'h0});
      acc(16'h0121, 0, 1, 1, 16'h0099);
      chk(s_err && !s_we, "R6 wide odd byte write blocked", {s_err, s_we}, 2'b10);
      acc(16'h0120, 1, 0, 0, 0);
      chk(r_data == {pat(16'h0121), pat(16'h0120)}, "R6 wide word unchanged",
          r_data, {pat(16'h0121), pat(16'h0120)});
      acc(16'h0120, 1, 0, 1, 0);
      chk(r_data == {8'h00, pat(16'h0120)}, "R5 wide even byte hi zero", r_data, {8'h00, pat(16'h0120)});
      acc(16'h0120, 0, 1, 0, 16'h1234);
      chk(s_we && s_be == 2'b11, "R7 wide word be", {s_we, s_be}, 3'b111);
      acc(16'h0120, 1, 0, 0, 0);
      chk(r_data == 16'h1234 && !r_warn, "R7 wide word readback", r_data, 16'h1234);
   endtask

   task automatic t_mem();
      acc(16'h0203, 0, 1, 0, 16'hAAAA);
      chk(s_err && !s_we && s_sel == 4'b0, "R6 mem odd word write blocked", {s_err, s_we, s_sel}, 6'b100000);
      acc(16'h0202, 1, 0, 0, 0);
      chk(r_data == {pat(16'h0203), pat(16'h0202)}, "R6 mem word unchanged",
          r_data, {pat(16'h0203), pat(16'h0202)});
      acc(16'h0301, 0, 1, 1, 16'h5577);
      chk(s_be == 2'b10 && s_wd[15:8] == 8'h77, "R7 mem odd byte lane", {s_be, s_wd}, {2'b10, 16'h7777});
      acc(16'h0301, 1, 0, 1, 0);
      chk(r_data == 16'h0077, "R8 mem odd byte read", r_data, 16'h0077);
      acc(16'h0300, 1, 0, 0, 0);
      chk(r_data == {8'h77, pat(16'h0300)}, "R8 mem word after byte write", r_data, {8'h77, pat(16'h0300)});
   endtask

   task automatic t_hold();
      logic [15:0] prev;
      prev = cpu_rdata;
      acc(16'h0300, 0, 0, 0, 0);
      chk(!r_valid && r_data == prev, "R9 idle holds data", {r_valid, r_data}, {1'b0, prev});
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_regions();
      t_ctrl();
      t_narrow();
      t_wide();
      t_mem();
      t_hold();
      finished = 1'b1;
      summary();
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         chk(1'b0, "watchdog", 0, 1);
         summary();
      end
   end

endmodule